// File: doc/BRIEF.md
# PWM Period and High-Time Capture

This block measures an incoming pulse-width-modulated signal with a single free-running 16-bit counter and two capture registers. The pin is first brought into the clock domain by a two-flop synchroniser. A digital filter then accepts a new level only after the synchronised sample has held it for a programmable number of consecutive clocks. Only then does an edge detector produce a clean event.

The edge of the selected polarity is the active edge. On this edge the counter value goes into the period register and the counter restarts from zero. The opposite edge copies the counter into the width register and leaves the counter running. Both results therefore come from one time base.

Each register has its own event divider, so a capture can be taken on every 1st, 2nd, 4th or 8th qualifying edge. Each register also has a valid flag and an overcapture flag, and one clear input drops all four flags. Working out the duty ratio from the two values is left to the consumer.

Top module: `pwm_capture`

## Requirements
- R1: After reset both capture registers read 0 and all four flags (period_vld, period_ovr, width_vld, width_ovr) are 0.
- R2: With inv_pol = 0, a rising edge of the filtered input loads period_o with (clock cycles since the previous active edge) − 1, modulo 65536, and restarts the counter from 0.
- R3: The edge opposite the active one loads width_o with (clock cycles since the last active edge) − 1 and does not restart the counter, so the following period value is unaffected.
- R4: With inv_pol = 1 the roles swap: a falling edge is the active edge that captures the period and restarts the counter, and a rising edge captures the width.
- R5: A level is accepted only after the synchronised input has shown it for filt_len + 1 consecutive clocks (filt_len is 0 to 7). A pulse shorter than that changes no output, and a pulse of exactly that length counts as two edges.
- R6: cap_div = d makes each register capture only on every 2^d-th edge of its own kind, counted from reset. The counter still restarts on every active edge, so a captured period is always a single period.
- R7: A capture sets the register's valid flag. flag_clr clears every valid and overcapture flag. When flag_clr coincides with a capture, the capturing register ends with valid = 1 and overcapture = 0.
- R8: A capture taken while that register's valid flag is still set, and not cleared in the same cycle, sets its overcapture flag. The flag stays set until flag_clr.
- R9: An input change placed between two clock edges appears in the capture registers on the (filt_len + 3)-th rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM signal to measure |
| inv_pol | input | 1 | 0: rising edge is active, 1: falling edge is active |
| filt_len | input | 3 | Filter length minus one (N = filt_len + 1 samples) |
| cap_div | input | 2 | Capture divider exponent (every 2^cap_div-th edge) |
| flag_clr | input | 1 | Clears all valid and overcapture flags |
| period_o | output | 16 | Captured period count |
| period_vld | output | 1 | Period capture flag |
| period_ovr | output | 1 | Period overcapture flag |
| width_o | output | 16 | Captured high-time (width) count |
| width_vld | output | 1 | Width capture flag |
| width_ovr | output | 1 | Width overcapture flag |

## Verification
An input change lands in a capture register exactly filt_len + 3 rising edges later: two edges for the synchroniser and filt_len + 1 for the filter, with the capture registered on the last of these. A directed probe samples the register one edge before that point and again on it. The bench also raises flag_clr on exactly that edge to test the clear-versus-capture priority. Every random segment lasts at least 12 clocks, which is more than the longest latency of 10 edges. Each comparison is made on the falling clock edge that closes a segment. The expected counts come from differences of the bench's own cycle counter, and the constant pipeline delay cancels out of those differences.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  localparam int N_CH      = 2;
  localparam int CH_PERIOD = 0;
  localparam int CH_WIDTH  = 1;

  // Last divider count before a capture is taken for exponent 'shift'.
  function automatic int unsigned div_last(input int unsigned shift);
    return (32'd1 << shift) - 32'd1;
  endfunction

  // Flag update: clear applies before a new capture in the same cycle.
  function automatic logic [1:0] flag_next(input logic take, input logic clr,
                                           input logic vld, input logic ovr);
    logic v_kept, o_kept;
    v_kept = vld & ~clr;
    o_kept = ovr & ~clr;
    return {o_kept | (take & v_kept), v_kept | take};
  endfunction
endpackage

// File: rtl/pwm_cap_filter.sv
module pwm_cap_filter #(
  parameter int FLT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             inv_pol,
  input  logic [FLT_W-1:0] filt_len,
  output logic             act_evt,
  output logic             inact_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [FLT_W-1:0]       run_q;
  logic                   smp, differ, accept, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  assign smp    = sync_q[SYNC_STAGES-1];
  assign differ = smp != lvl_q;
  assign accept = differ && (run_q == filt_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (!differ) begin
      run_q <= '0;
    end else if (accept) begin
      lvl_q <= smp;
      run_q <= '0;
    end else begin
      run_q <= run_q + FLT_W'(1);
    end
  end

  assign rise      = accept & smp;
  assign fall      = accept & ~smp;
  assign act_evt   = inv_pol ? fall : rise;
  assign inact_evt = inv_pol ? rise : fall;
endmodule

// File: rtl/pwm_cap_timebase.sv
module pwm_cap_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_cap_channel.sv
module pwm_cap_channel import pwm_cap_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [DIV_W-1:0] cap_div,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_o,
  output logic             vld_o,
  output logic             ovr_o,
  output logic             take_o
);
  localparam int PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] div_q;
  logic [1:0]      fl_d;

  assign take_o = evt && (div_q == PS_W'(div_last(32'(cap_div))));
  assign fl_d   = flag_next(take_o, flag_clr, vld_o, ovr_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cap_o <= '0;
      vld_o <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      if (evt) div_q <= take_o ? '0 : div_q + PS_W'(1);
      if (take_o) cap_o <= cnt;
      vld_o <= fl_d[0];
      ovr_o <= fl_d[1];
    end
  end
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture import pwm_cap_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 3,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             inv_pol,
  input  logic [FLT_W-1:0] filt_len,
  input  logic [DIV_W-1:0] cap_div,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] period_o,
  output logic             period_vld,
  output logic             period_ovr,
  output logic [CNT_W-1:0] width_o,
  output logic             width_vld,
  output logic             width_ovr
);
  logic             act_evt, inact_evt;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0]  ch_evt, ch_take, ch_vld, ch_ovr;
  logic [CNT_W-1:0] ch_val [N_CH];
  logic             period_take, width_take;

  pwm_cap_filter #(.FLT_W(FLT_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(pwm_in), .inv_pol(inv_pol),
    .filt_len(filt_len), .act_evt(act_evt), .inact_evt(inact_evt)
  );

  pwm_cap_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .restart(act_evt), .cnt(cnt)
  );

  assign ch_evt[CH_PERIOD] = act_evt;
  assign ch_evt[CH_WIDTH]  = inact_evt;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_cap_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .evt(ch_evt[g]), .cap_div(cap_div),
      .flag_clr(flag_clr), .cnt(cnt), .cap_o(ch_val[g]),
      .vld_o(ch_vld[g]), .ovr_o(ch_ovr[g]), .take_o(ch_take[g])
    );
  end

  assign period_take = ch_take[CH_PERIOD];
  assign width_take  = ch_take[CH_WIDTH];
  assign period_o    = ch_val[CH_PERIOD];
  assign period_vld  = ch_vld[CH_PERIOD];
  assign period_ovr  = ch_ovr[CH_PERIOD];
  assign width_o     = ch_val[CH_WIDTH];
  assign width_vld   = ch_vld[CH_WIDTH];
  assign width_ovr   = ch_ovr[CH_WIDTH];
endmodule

// File: rtl/pwm_capture_chk.sv
module pwm_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flag_clr,
  input logic             act_evt,
  input logic             inact_evt,
  input logic [CNT_W-1:0] cnt,
  input logic             period_take,
  input logic             width_take,
  input logic [CNT_W-1:0] period_o,
  input logic             period_vld,
  input logic             period_ovr,
  input logic [CNT_W-1:0] width_o,
  input logic             width_vld,
  input logic             width_ovr
);
  a_r2_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> cnt == '0);

  a_r3_cnt_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !act_evt |=> cnt == $past(cnt) + CNT_W'(1));

  a_r2_period_value: assert property (@(posedge clk) disable iff (!rst_n)
    period_take |=> period_o == $past(cnt));

  a_r3_width_value: assert property (@(posedge clk) disable iff (!rst_n)
    width_take |=> width_o == $past(cnt));

  a_r3_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !width_take |=> $stable(width_o));

  a_r6_take_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (period_take |-> act_evt) and (width_take |-> inact_evt));

  a_r7_vld_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    period_take |=> period_vld && !($past(flag_clr) && period_ovr));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !width_take |=> !width_vld && !width_ovr);

  a_r8_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
    width_take && width_vld && !flag_clr |=> width_ovr);
endmodule

bind pwm_capture pwm_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .act_evt(act_evt),
  .inact_evt(inact_evt), .cnt(cnt), .period_take(period_take),
  .width_take(width_take), .period_o(period_o), .period_vld(period_vld),
  .period_ovr(period_ovr), .width_o(width_o), .width_vld(width_vld),
  .width_ovr(width_ovr)
);

// File: tb/pwm_capture_tb.sv
module pwm_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_in = 1'b0;
  logic        inv_pol = 1'b0;
  logic [2:0]  filt_len = '0;
  logic [1:0]  cap_div = '0;
  logic        flag_clr = 1'b0;
  logic [15:0] period_o, width_o;
  logic        period_vld, period_ovr, width_vld, width_ovr;

  pwm_capture u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .inv_pol(inv_pol),
    .filt_len(filt_len), .cap_div(cap_div), .flag_clr(flag_clr),
    .period_o(period_o), .period_vld(period_vld), .period_ovr(period_ovr),
    .width_o(width_o), .width_vld(width_vld), .width_ovr(width_ovr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  // bench model state
  int  nsmp, kdiv, pcnt, wcnt, last_act;
  bit  have_act, lvl;
  bit  per_known, wid_known, ev_p, eo_p, ev_w, eo_w;
  logic [15:0] exp_per, exp_wid;

  function automatic logic [15:0] count_between(int t_now, int t_then);
    return 16'(t_now - t_then - 1);
  endfunction

  function automatic bit is_take(int edges, int k);
    return (edges % k) == 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    nsmp = int'(filt_len) + 1; kdiv = 1 << cap_div;
    pcnt = 0; wcnt = 0; last_act = 0; have_act = 0; lvl = 0;
    per_known = 1; wid_known = 1; exp_per = '0; exp_wid = '0;
    ev_p = 0; eo_p = 0; ev_w = 0; eo_w = 0;
  endtask

  task automatic model_edge(bit lv, bit clr_same);
    bit active;
    active = inv_pol ? !lv : lv;
    if (clr_same) begin ev_p = 0; eo_p = 0; ev_w = 0; eo_w = 0; end
    if (active) begin
      pcnt++;
      if (is_take(pcnt, kdiv)) begin
        per_known = have_act;
        if (have_act) exp_per = count_between(cyc, last_act);
        eo_p = eo_p | ev_p; ev_p = 1;
      end
      last_act = cyc; have_act = 1;
    end else begin
      wcnt++;
      if (is_take(wcnt, kdiv)) begin
        wid_known = have_act;
        if (have_act) exp_wid = count_between(cyc, last_act);
        eo_w = eo_w | ev_w; ev_w = 1;
      end
    end
  endtask

  task automatic do_reset(bit inv, int fl, int dv);
    @(negedge clk);
    rst_n = 0; pwm_in = 0; flag_clr = 0;
    inv_pol = inv; filt_len = 3'(fl); cap_div = 2'(dv);
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic check_all(string ptag, string wtag);
    if (per_known) chk(ptag, "period_o", int'(period_o), int'(exp_per));
    if (wid_known) chk(wtag, "width_o", int'(width_o), int'(exp_wid));
    chk("R7", "period_vld", int'(period_vld), int'(ev_p));
    chk("R8", "period_ovr", int'(period_ovr), int'(eo_p));
    chk("R7", "width_vld", int'(width_vld), int'(ev_w));
    chk("R8", "width_ovr", int'(width_ovr), int'(eo_w));
  endtask

  // drive a new level and hold it for len clocks (len >= 12 when clr_same)
  task automatic seg(bit lv, int len, bit clr_same);
    pwm_in = lv; lvl = lv;
    model_edge(lv, clr_same);
    if (clr_same) begin
      repeat (nsmp + 1) @(negedge clk);
      flag_clr = 1;
      @(negedge clk);
      flag_clr = 0;
      repeat (len - nsmp - 2) @(negedge clk);
    end else begin
      repeat (len) @(negedge clk);
    end
  endtask

  task automatic hold(int len);
    repeat (len) @(negedge clk);
  endtask

  task automatic glitch(int g);
    pwm_in = !lvl;
    repeat (g) @(negedge clk);
    pwm_in = lvl;
  endtask

  task automatic clear_flags();
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    ev_p = 0; eo_p = 0; ev_w = 0; eo_w = 0;
  endtask

  // R9: exact latency of a capture (cap_div must be 0)
  task automatic lat_probe(bit lv, int len);
    logic [15:0] old_p, old_w;
    old_p = exp_per; old_w = exp_wid;
    pwm_in = lv; lvl = lv;
    model_edge(lv, 0);
    repeat (nsmp + 1) @(negedge clk);
    chk("R9", "period_o before due edge", int'(period_o), int'(old_p));
    chk("R9", "width_o before due edge", int'(width_o), int'(old_w));
    @(negedge clk);
    chk("R9", "period_o on due edge", int'(period_o), int'(exp_per));
    chk("R9", "width_o on due edge", int'(width_o), int'(exp_wid));
    repeat (len - nsmp - 2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));

    // ---- directed: rising active, N = 4, no division
    do_reset(0, 3, 0);
    hold(4);
    chk("R1", "period_o", int'(period_o), 0);
    chk("R1", "width_o", int'(width_o), 0);
    chk("R1", "flags", int'({period_vld, period_ovr, width_vld, width_ovr}), 0);
    seg(1, 20, 0); seg(0, 30, 0); seg(1, 25, 0);
    check_all("R2", "R3");
    lat_probe(0, 40);               // width capture latency (R9)
    lat_probe(1, 33);               // period capture latency (R9)
    check_all("R2", "R3");
    clear_flags();
    check_all("R7", "R7");
    glitch(3); hold(20);            // shorter than N: ignored (R5)
    check_all("R5", "R5");
    glitch(1); hold(15);
    check_all("R5", "R5");
    seg(0, 4, 0); seg(1, 30, 0);    // exactly N: accepted as two edges (R5)
    check_all("R5", "R5");
    seg(0, 18, 1);                  // clear coincides with width capture (R7)
    check_all("R2", "R7");
    seg(1, 22, 0); seg(0, 14, 0);   // overcapture on width (R8)
    check_all("R2", "R8");

    // ---- directed: inverted polarity (R4)
    do_reset(1, 0, 0);
    seg(1, 40, 0); seg(0, 17, 0); seg(1, 29, 0); seg(0, 55, 0);
    check_all("R4", "R4");
    seg(1, 12, 0); seg(0, 12, 0);
    check_all("R4", "R4");

    // ---- directed: divider by 4 (R6)
    do_reset(0, 1, 2);
    for (int i = 0; i < 16; i++) begin
      seg(!lvl, 12 + i * 3, 0);
      check_all("R2+R6", "R3+R6");
    end

    // ---- constrained random
    for (int sc = 0; sc < 8; sc++) begin
      bit inv;
      int fl, dv;
      inv = 1'($urandom);
      fl  = int'($urandom % 8);
      dv  = int'($urandom % 4);
      do_reset(inv, fl, dv);
      for (int s = 0; s < 45; s++) begin
        int  len;
        bit  cs;
        len = 12 + int'($urandom % 220);
        cs  = ($urandom % 10) == 0;
        seg(!lvl, len, cs);
        check_all(inv ? "R4" : "R2", dv != 0 ? "R6" : "R3");
        if (nsmp > 1 && ($urandom % 7) == 0) begin
          glitch(1 + int'($urandom % (nsmp - 1)));
          hold(12);
          check_all("R5", "R5");
        end
        if (($urandom % 6) == 0) begin
          clear_flags();
          check_all("R7", "R7");
        end
      end
    end

    finish_run();
  end
endmodule